// File: doc/BRIEF.md
# Half-Duplex Jam and Jabber Controller

This block sits beside the transmit path of a half-duplex Ethernet MAC and works at byte granularity. A free-running byte-time enable (`byte_tick`) paces it. The MAC presents, on each tick, whether it is sending a byte and what kind of byte it is: first, last, preamble, or start-of-frame delimiter. The block watches the MII collision and carrier lines and tells the MAC when to replace its data with a jam pattern and when to give up on the current frame.

Three functions share one sequencer.

- **Collisions.** A collision seen in half-duplex mode produces a fixed-length jam followed by an abort. If the collision lands during the preamble, the jam is deferred until the delimiter has gone out.
- **Back pressure.** When the application asks for it, the block forces a collision on each arriving receive carrier by jamming for a programmable number of bytes. This happens once per carrier event, and a local frame is never held off.
- **Jabber guard.** Data bytes are counted per frame. A frame that runs past the limit is cut off and a sticky flag is raised.

Top module: `hd_jam_guard`

## Requirements
- R1: After reset, `jam_on`, `tx_abort`, `jab_flag` and `col_flag` are 0 and `jam_byte` is 0.
- R2: In half-duplex mode, a collision sampled on a tick that carries a frame byte with `tx_pre`=0 or `tx_sfd`=1 raises `jam_on` after that tick.
  - `jam_on` stays high for exactly JAM_BYTES further ticks.
  - While `jam_on` is high, `jam_byte` is the alternating pattern with bit 0 set (8'h55 at 8 bits); otherwise `jam_byte` is 0.
- R3: A collision sampled on a preamble byte (`tx_pre`=1, `tx_sfd`=0) keeps `jam_on` low until the tick carrying the delimiter byte (`tx_sfd`=1). The jam of R2 then starts after that tick.
- R4: On the tick that ends a collision jam, `tx_abort` pulses for one clock.
  - `col_flag` is set by the collision.
  - `col_flag` stays set until the next frame start without a collision clears it.
- R5: With `hdx_mode`=0, `mii_col` is ignored: no jam, no abort, and `col_flag` stays 0.
- R6: Data bytes (`tx_pre`=0) are counted from frame start. With `jab_dis`=0, the tick carrying data byte number JAB_LIMIT+1 pulses `tx_abort` without any jam and sets `jab_flag`. A frame of at most JAB_LIMIT data bytes is left alone.
- R7: With `jab_dis`=1, frames of any length run to their last byte with no abort.
- R8: `jab_flag` stays set across later frames until `jab_clr` is asserted; it then reads 0.
- R9: With `hdx_mode`, `tfc_en` and `bp_req` all 1 and no frame in progress, a tick that sees `mii_crs` high raises `jam_on` for exactly BP_JAM_BYTES ticks. No abort follows.
- R10: If any one of `hdx_mode`, `tfc_en`, `bp_req` is 0, receive carrier never causes a jam.
- R11: Back-pressure jamming fires at most once per carrier event. It fires again only after `mii_crs` has been seen low.
- R12: While back pressure is requested, a local frame start is accepted even when the carrier is high, and the frame runs unjammed. Carrier that stays high across the end of a local frame does not trigger a back-pressure jam.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_tick | input | 1 | One-cycle pulse per byte time; all sequencing advances on it |
| tx_valid | input | 1 | MAC is sending a byte in this byte time |
| tx_sof | input | 1 | The byte is the first of a frame |
| tx_eof | input | 1 | The byte is the last of a frame |
| tx_pre | input | 1 | The byte belongs to the preamble or the delimiter |
| tx_sfd | input | 1 | The byte is the start-of-frame delimiter |
| mii_col | input | 1 | Collision detect from the MII |
| mii_crs | input | 1 | Carrier sense from the MII |
| bp_req | input | 1 | Back-pressure request from the application |
| tfc_en | input | 1 | Transmit flow-control enable |
| hdx_mode | input | 1 | 1 = half-duplex operation |
| jab_dis | input | 1 | 1 = jabber cutoff disabled |
| jab_clr | input | 1 | Clears the jabber status flag |
| jam_on | output | 1 | MAC must send `jam_byte` instead of its data |
| jam_byte | output | DW | Jam data byte |
| tx_abort | output | 1 | One-clock pulse: abandon the current frame |
| jab_flag | output | 1 | Sticky jabber-timeout status |
| col_flag | output | 1 | Collision seen in the current or last frame |

## Verification
The bench builds the block with JAM_BYTES=4, BP_JAM_BYTES=6 and JAB_LIMIT=12, and inserts an idle clock between byte ticks.

These small values allow several full sweeps:
- a collision on every byte position of a 14-byte frame, from the start byte through the last data byte;
- frame lengths just below, at and above the jabber limit, with the cutoff both enabled and disabled;
- every combination of the three back-pressure enables.

Two carrier events per case show both the once-only firing and the re-arm, and jam end tick and abort tick are predicted arithmetically for each case.

// File: rtl/hd_jam_pkg.sv
package hd_jam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TX    = 3'd1,
    ST_PEND  = 3'd2,
    ST_JAM   = 3'd3,
    ST_BPJAM = 3'd4
  } hd_state_e;

endpackage

// File: rtl/hd_jabber.sv
module hd_jabber #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic restart_data,
  input  logic data_tick,
  input  logic trip,
  input  logic clr,
  output logic at_limit,
  output logic flag
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  // data byte counter, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= CW'(restart_data);
    end else if (data_tick && (cnt_q != CW'(LIMIT))) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // sticky timeout status, a new trip wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (trip) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

  assign at_limit = (cnt_q == CW'(LIMIT));
  assign flag     = flag_q;

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);

  a_r6_count_capped: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(LIMIT) && !restart) |=> (cnt_q == CW'(LIMIT)));

endmodule

// File: rtl/hd_bp_arm.sv
module hd_bp_arm (
  input  logic clk,
  input  logic rst,
  input  logic crs,
  input  logic busy,
  input  logic fire_ok,
  output logic fire
);

  logic armed_q;

  assign fire = fire_ok && armed_q && crs;

  // disarmed by firing or by any local activity, re-armed by quiet carrier
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (fire || busy) begin
      armed_q <= 1'b0;
    end else if (!crs) begin
      armed_q <= 1'b1;
    end
  end

  a_r11_fire_disarms: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed_q);

  a_r11_rearm_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(!crs));

endmodule

// File: rtl/hd_jam_seq.sv
module hd_jam_seq
  import hd_jam_pkg::*;
#(
  parameter int DW           = 8,
  parameter int JAM_BYTES    = 4,
  parameter int BP_JAM_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_tick,
  input  logic          tx_valid,
  input  logic          tx_sof,
  input  logic          tx_eof,
  input  logic          tx_pre,
  input  logic          tx_sfd,
  input  logic          mii_col,
  input  logic          hdx_mode,
  input  logic          tfc_en,
  input  logic          bp_req,
  input  logic          jab_dis,
  input  logic          at_limit,
  input  logic          bp_fire,
  output logic          busy,
  output logic          bp_ok,
  output logic          frame_start,
  output logic          start_data,
  output logic          data_tick,
  output logic          jab_trip,
  output logic          jam_on,
  output logic [DW-1:0] jam_byte,
  output logic          abort,
  output logic          col_flag
);

  localparam int MAXJ = (JAM_BYTES > BP_JAM_BYTES) ? JAM_BYTES : BP_JAM_BYTES;
  localparam int JCW  = $clog2(MAXJ + 1);

  hd_state_e      st_q, st_d;
  logic [JCW-1:0] cnt_q, cnt_d;
  logic           abort_q, abort_d;
  logic           jam_on_q;
  logic [DW-1:0]  jam_byte_q;
  logic           col_flag_q;
  logic [DW-1:0]  pat;

  // alternating 1/0 pattern, bit 0 set
  for (genvar g = 0; g < DW; g++) begin : g_pat
    assign pat[g] = ((g % 2) == 0);
  end

  logic col_hit, tx_tick, frame_tick, pre_only, col_go, in_jam_d;

  assign col_hit     = hdx_mode && mii_col;
  assign frame_start = byte_tick && tx_valid && tx_sof && (st_q == ST_IDLE);
  assign tx_tick     = byte_tick && tx_valid && (st_q == ST_TX);
  assign frame_tick  = frame_start || tx_tick;
  assign pre_only    = tx_pre && !tx_sfd;
  assign col_go      = frame_tick && col_hit;
  assign start_data  = !tx_pre;
  assign data_tick   = tx_tick && !tx_pre;
  assign jab_trip    = data_tick && at_limit && !jab_dis && !col_hit;
  assign busy        = (st_q != ST_IDLE);
  assign bp_ok       = byte_tick && (st_q == ST_IDLE) && !(tx_valid && tx_sof)
                       && hdx_mode && tfc_en && bp_req;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    abort_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (frame_start) begin
          cnt_d = '0;
          if (col_go) st_d = pre_only ? ST_PEND : ST_JAM;
          else        st_d = ST_TX;
        end else if (bp_fire) begin
          cnt_d = '0;
          st_d  = ST_BPJAM;
        end
      end
      ST_TX: begin
        if (tx_tick) begin
          if (col_go) begin
            cnt_d = '0;
            st_d  = pre_only ? ST_PEND : ST_JAM;
          end else if (jab_trip) begin
            st_d    = ST_IDLE;
            abort_d = 1'b1;
          end else if (tx_eof) begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_PEND: begin
        if (byte_tick && tx_valid && !pre_only) begin
          cnt_d = '0;
          st_d  = ST_JAM;
        end
      end
      ST_JAM: begin
        if (byte_tick) begin
          if (cnt_q == JCW'(JAM_BYTES - 1)) begin
            st_d    = ST_IDLE;
            abort_d = 1'b1;
          end else begin
            cnt_d = cnt_q + JCW'(1);
          end
        end
      end
      ST_BPJAM: begin
        if (byte_tick) begin
          if (cnt_q == JCW'(BP_JAM_BYTES - 1)) st_d = ST_IDLE;
          else cnt_d = cnt_q + JCW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign in_jam_d = (st_d == ST_JAM) || (st_d == ST_BPJAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      abort_q    <= 1'b0;
      jam_on_q   <= 1'b0;
      jam_byte_q <= '0;
      col_flag_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      abort_q    <= abort_d;
      jam_on_q   <= in_jam_d;
      jam_byte_q <= in_jam_d ? pat : '0;
      if (frame_start)  col_flag_q <= col_go;
      else if (col_go)  col_flag_q <= 1'b1;
    end
  end

  assign jam_on   = jam_on_q;
  assign jam_byte = jam_byte_q;
  assign abort    = abort_q;
  assign col_flag = col_flag_q;

  a_r2_jam_bounded: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_JAM) |-> (cnt_q < JCW'(JAM_BYTES)));

  a_r3_pend_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PEND && !(byte_tick && tx_valid && !(tx_pre && !tx_sfd)))
    |=> (st_q == ST_PEND && !jam_on_q));

  a_r5_fdx_no_col: assert property (@(posedge clk) disable iff (rst)
    (!hdx_mode && st_q == ST_TX) |=> !(st_q == ST_JAM || st_q == ST_PEND));

  a_r9_bp_no_abort: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BPJAM) |=> !abort_q);

endmodule

// File: rtl/hd_jam_guard.sv
module hd_jam_guard #(
  parameter int DW           = 8,
  parameter int JAM_BYTES    = 4,
  parameter int BP_JAM_BYTES = 32,
  parameter int JAB_LIMIT    = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_tick,
  input  logic          tx_valid,
  input  logic          tx_sof,
  input  logic          tx_eof,
  input  logic          tx_pre,
  input  logic          tx_sfd,
  input  logic          mii_col,
  input  logic          mii_crs,
  input  logic          bp_req,
  input  logic          tfc_en,
  input  logic          hdx_mode,
  input  logic          jab_dis,
  input  logic          jab_clr,
  output logic          jam_on,
  output logic [DW-1:0] jam_byte,
  output logic          tx_abort,
  output logic          jab_flag,
  output logic          col_flag
);

  logic busy, bp_ok, bp_fire, frame_start, start_data, data_tick;
  logic jab_trip, at_limit;

  hd_jam_seq #(
    .DW          (DW),
    .JAM_BYTES   (JAM_BYTES),
    .BP_JAM_BYTES(BP_JAM_BYTES)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .byte_tick  (byte_tick),
    .tx_valid   (tx_valid),
    .tx_sof     (tx_sof),
    .tx_eof     (tx_eof),
    .tx_pre     (tx_pre),
    .tx_sfd     (tx_sfd),
    .mii_col    (mii_col),
    .hdx_mode   (hdx_mode),
    .tfc_en     (tfc_en),
    .bp_req     (bp_req),
    .jab_dis    (jab_dis),
    .at_limit   (at_limit),
    .bp_fire    (bp_fire),
    .busy       (busy),
    .bp_ok      (bp_ok),
    .frame_start(frame_start),
    .start_data (start_data),
    .data_tick  (data_tick),
    .jab_trip   (jab_trip),
    .jam_on     (jam_on),
    .jam_byte   (jam_byte),
    .abort      (tx_abort),
    .col_flag   (col_flag)
  );

  hd_jabber #(.LIMIT(JAB_LIMIT)) u_jab (
    .clk         (clk),
    .rst         (rst),
    .restart     (frame_start),
    .restart_data(start_data),
    .data_tick   (data_tick),
    .trip        (jab_trip),
    .clr         (jab_clr),
    .at_limit    (at_limit),
    .flag        (jab_flag)
  );

  hd_bp_arm u_bp (
    .clk    (clk),
    .rst    (rst),
    .crs    (mii_crs),
    .busy   (busy),
    .fire_ok(bp_ok),
    .fire   (bp_fire)
  );

  a_r4_abort_one_clock: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !tx_abort);

  a_r2_abort_not_jamming: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> !jam_on);

endmodule

// File: tb/sim_hd_jam_guard.sv
module sim_hd_jam_guard;

  localparam int JAM = 4;
  localparam int BPJ = 6;
  localparam int LIM = 12;
  localparam int NPRE = 3;   // preamble bytes before the delimiter
  localparam int SFDI = NPRE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_tick = 0, tx_valid = 0, tx_sof = 0, tx_eof = 0, tx_pre = 0, tx_sfd = 0;
  logic mii_col = 0, mii_crs = 0, bp_req = 0, tfc_en = 0, hdx_mode = 1, jab_dis = 0, jab_clr = 0;
  logic       jam_on, tx_abort, jab_flag, col_flag;
  logic [7:0] jam_byte;

  int n_tests = 0;
  int n_fail  = 0;
  logic s_jam, s_abort;
  logic [7:0] s_byte;

  always #5 clk = ~clk;

  hd_jam_guard #(.DW(8), .JAM_BYTES(JAM), .BP_JAM_BYTES(BPJ), .JAB_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .byte_tick(byte_tick), .tx_valid(tx_valid), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_pre(tx_pre), .tx_sfd(tx_sfd), .mii_col(mii_col), .mii_crs(mii_crs),
    .bp_req(bp_req), .tfc_en(tfc_en), .hdx_mode(hdx_mode), .jab_dis(jab_dis), .jab_clr(jab_clr),
    .jam_on(jam_on), .jam_byte(jam_byte), .tx_abort(tx_abort), .jab_flag(jab_flag),
    .col_flag(col_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one byte time: tick cycle then an idle cycle; outputs captured after the tick edge
  task automatic tk(input logic v, input logic sof, input logic eof, input logic pre,
                    input logic sfd, input logic col, input logic crs);
    tx_valid = v; tx_sof = sof; tx_eof = eof; tx_pre = pre; tx_sfd = sfd;
    mii_col = col; mii_crs = crs; byte_tick = 1'b1;
    @(negedge clk);
    s_jam = jam_on; s_abort = tx_abort; s_byte = jam_byte;
    byte_tick = 1'b0; tx_sof = 1'b0; tx_eof = 1'b0; mii_col = 1'b0;
    @(negedge clk);
  endtask

  task automatic clean_frame(input int nd, input logic crs, input string req);
    for (int i = 0; i <= NPRE + nd; i++) begin
      tk(1'b1, i == 0, i == NPRE + nd, i <= SFDI, i == SFDI, 1'b0, crs);
      chk(req, s_jam, 0);
      chk(req, s_abort, 0);
    end
    tx_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 jam_on", jam_on, 0);
    chk("R1 tx_abort", tx_abort, 0);
    chk("R1 jab_flag", jab_flag, 0);
    chk("R1 col_flag", col_flag, 0);
    chk("R1 jam_byte", jam_byte, 0);

    // R2/R3/R4: collision on every byte of a 14-byte frame
    hdx_mode = 1'b1;
    for (int k = 0; k <= SFDI + 10; k++) begin
      int s;
      int last;
      string tag;
      s = (k < SFDI) ? SFDI : k;
      last = SFDI + 10;
      tag = (k < SFDI) ? "R3 deferred jam" : "R2 jam";
      for (int i = 0; i <= s + JAM + 1; i++) begin
        logic v;
        logic ej;
        v = (i <= last) && (i < s + JAM);
        tk(v, i == 0, i == last, i <= SFDI, i == SFDI, i == k, 1'b0);
        ej = (i >= s) && (i < s + JAM);
        chk(tag, s_jam, ej);
        chk("R4 abort pulse", s_abort, (i == s + JAM));
        chk("R2 jam byte", s_byte, ej ? 8'h55 : 8'h00);
      end
      chk("R4 col_flag set", col_flag, 1);
      tk(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R4 col_flag cleared on new frame", col_flag, 0);
      for (int i = 1; i <= SFDI + 2; i++) begin
        tk(1'b1, 1'b0, i == SFDI + 2, i <= SFDI, i == SFDI, 1'b0, 1'b0);
        chk("R4 clean frame no jam", s_jam, 0);
      end
      tx_valid = 1'b0;
    end

    // R5: full duplex ignores collision
    hdx_mode = 1'b0;
    for (int i = 0; i <= SFDI + 8; i++) begin
      tk(1'b1, i == 0, i == SFDI + 8, i <= SFDI, i == SFDI, 1'b1, 1'b0);
      chk("R5 no jam", s_jam, 0);
      chk("R5 no abort", s_abort, 0);
    end
    chk("R5 col_flag", col_flag, 0);
    hdx_mode = 1'b1;

    // R6/R7/R8: jabber around the limit
    for (int dis = 0; dis <= 1; dis++) begin
      for (int dd = 0; dd < 4; dd++) begin
        int nd;
        int t;
        int last;
        bit trip;
        nd = (dd == 3) ? LIM + 3 : LIM - 1 + dd;
        last = SFDI + nd;
        trip = (nd > LIM) && (dis == 0);
        t = trip ? SFDI + 1 + LIM : 1000;
        jab_dis = logic'(dis);
        for (int i = 0; i <= last; i++) begin
          if (i <= t) begin
            tk(1'b1, i == 0, i == last, i <= SFDI, i == SFDI, 1'b0, 1'b0);
            chk(dis ? "R7 no cutoff" : "R6 cutoff", s_abort, (i == t));
            chk("R6 no jam on cutoff", s_jam, 0);
          end
        end
        tx_valid = 1'b0;
        chk("R6 jab_flag", jab_flag, trip);
        if (trip) begin
          clean_frame(3, 1'b0, "R8 normal frame");
          chk("R8 sticky", jab_flag, 1);
          jab_clr = 1'b1;
          @(negedge clk);
          jab_clr = 1'b0;
          chk("R8 cleared", jab_flag, 0);
        end
      end
    end
    jab_dis = 1'b0;

    // R9/R10/R11: back pressure over all enable combinations, two carrier events
    for (int c = 0; c < 8; c++) begin
      bit fires;
      hdx_mode = logic'(c[0]);
      tfc_en   = logic'(c[1]);
      bp_req   = logic'(c[2]);
      fires = (c == 7);
      for (int ev = 0; ev < 2; ev++) begin
        tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int j = 0; j < BPJ + 3; j++) begin
          tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
          if (fires) chk(j < BPJ ? "R9 bp jam" : "R11 no refire", s_jam, (j < BPJ));
          else       chk("R10 disabled", s_jam, 0);
          chk("R9 no abort", s_abort, 0);
          if (fires && j < BPJ) chk("R9 jam byte", s_byte, 8'h55);
        end
      end
      tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R12: local frames under back pressure
    hdx_mode = 1'b1; tfc_en = 1'b1; bp_req = 1'b1;
    clean_frame(5, 1'b0, "R12 local frame quiet carrier");
    tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    clean_frame(5, 1'b1, "R12 local frame carrier high");
    for (int j = 0; j < 3; j++) begin
      tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R12 no jam after own frame", s_jam, 0);
    end
    tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 rearmed after carrier low", s_jam, 1);
    for (int j = 1; j < BPJ + 1; j++) tk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 bp jam ended", s_jam, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule